// File: doc/BRIEF.md
# Serial Flash Subsector Erase Controller

Slave-side command logic for a serial NOR flash with a small behavioural storage array. It receives commands over SPI mode 0 (clock idle low, data sampled on rising SCK, driven on falling SCK). It keeps a write-enable latch and a busy flag and returns them through a status-read command. A correctly framed subsector-erase command, sent while the latch is set, starts a self-timed cycle that writes FFh into every byte of the addressed subsector. The command is refused if the subsector is protected or another cycle is still running.

The SPI inputs are sampled by the system clock and must be synchronous to it, with each SCK level held for at least two clock cycles. Default sizes are reduced so the array is cheap to elaborate: 128 bytes in 16-byte subsectors. Full-size parts set `ARR_AW=19` and `SUB_AW=12`, which gives 512 KiB in 4 KiB subsectors. Address bits above `ARR_AW` are ignored. A test port gives direct byte access to the array so that contents can be loaded and inspected. Driving the asynchronous reset low aborts a running erase. After reset is released, a recovery window of `REC_CYC` clocks follows, and any frame that begins inside it is ignored.

Top module: `sfe_subsector_erase`

## Requirements
- R1: An erase command is executed only when the write-enable latch (status bit 1) is set; otherwise the array and status are unchanged.
- R2: Opcode 06h followed by chip select rising after exactly 8 bits, with no cycle running, sets status bit 1.
- R3: Opcode 20h starts an erase only if chip select rises after exactly 32 bits (opcode plus 24 address bits, MSB first); a rise after 31, 36 or 40 bits discards it.
- R4: An erase writes FFh into every byte of the subsector given by address bits [ARR_AW-1:SUB_AW], whatever the offset bits are; other subsectors are unchanged.
- R5: Status bit 0 is 1 for exactly ERASE_CYC clocks, starting the clock after chip select rises, and 0 otherwise. Opcode 05h shifts the status byte out MSB first on falling SCK and repeats it while chip select stays low, sampling the status live.
- R6: The write-enable latch clears WEL_CLR_CYC clocks into the erase, while status bit 0 is still 1.
- R7: An erase aimed at a subsector whose `prot_i` bit is set is not executed.
- R8: Write-enable and erase commands that arrive while an erase runs are rejected; the running erase keeps its subsector and completes.
- R9: Reset low during an erase aborts it: status reads 00h afterwards and bytes the erase had not yet reached keep their old value.
- R10: A frame whose chip-select fall comes within REC_CYC clocks of reset release is ignored in full.
- R11: Address bits above ARR_AW-1 (A23 down to A19 at full size) do not affect subsector selection.
- R12: Opcodes other than 05h, 06h and 20h have no effect on the array or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, samples the SPI pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI serial clock (mode 0) |
| mosi_i | input | 1 | SPI data into the device |
| miso_o | output | 1 | SPI data out of the device |
| prot_i | input | NSUB | Per-subsector protection flags |
| mem_we_i | input | 1 | Test-port byte write strobe |
| mem_addr_i | input | ARR_AW | Test-port byte address |
| mem_wdata_i | input | 8 | Test-port write data |
| mem_rdata_o | output | 8 | Test-port read data (combinational) |

## Verification
A pin edge is seen one clock after it is driven. An accepted erase therefore raises busy on the clock edge that detects the chip-select rise. It writes byte k of the subsector k+1 clocks later, clears the latch WEL_CLR_CYC clocks in and drops busy ERASE_CYC clocks in. Each MISO bit is updated one clock after the falling SCK. The bench drives every SCK level for two clocks and samples MISO just before the next rising edge. Array checks run only after at least ERASE_CYC plus a margin, and the latch-before-busy ordering is checked by reading status continuously and looking at the order of the returned bytes.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_SUBERS = 8'h20;
  localparam int BUSY_BIT = 0;
  localparam int WEL_BIT  = 1;
  localparam int CNT_W    = 6;  // saturating SCK edge counter
endpackage

// File: rtl/sfe_spi_rx.sv
module sfe_spi_rx
  import sfe_pkg::*;
#(
  parameter int ARR_AW = 7,
  parameter int SUB_AW = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cs_ni,
  input  logic                     sck_i,
  input  logic                     mosi_i,
  input  logic                     lock_i,
  input  logic [7:0]               status_i,
  output logic                     miso_o,
  output logic                     cmd_end_o,
  output logic [CNT_W-1:0]         nbits_o,
  output logic [7:0]               op_o,
  output logic [ARR_AW-SUB_AW-1:0] idx_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic cs_q, sck_q, active, miso_q;
  logic [ARR_AW-1:0] addr_q;
  logic [2:0] rd_idx;

  wire cs_fall  = cs_q & ~cs_ni;
  wire cs_rise  = ~cs_q & cs_ni;
  wire sck_rise = ~sck_q & sck_i;
  wire sck_fall = sck_q & ~sck_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= 1'b1;
      sck_q   <= 1'b0;
      active  <= 1'b0;
      nbits_o <= '0;
      op_o    <= '0;
      addr_q  <= '0;
      miso_q  <= 1'b0;
      rd_idx  <= 3'd7;
    end else begin
      cs_q  <= cs_ni;
      sck_q <= sck_i;
      if (cs_fall) begin
        active  <= ~lock_i;  // frames opened during recovery stay dead
        nbits_o <= '0;
        rd_idx  <= 3'd7;
        miso_q  <= 1'b0;
      end else if (cs_rise) begin
        active <= 1'b0;
      end else if (active && sck_rise) begin
        if (nbits_o != CNT_MAX) nbits_o <= nbits_o + 1'b1;
        if (nbits_o < CNT_W'(8)) op_o <= {op_o[6:0], mosi_i};
        else if (nbits_o < CNT_W'(32)) addr_q <= {addr_q[ARR_AW-2:0], mosi_i};
      end else if (active && sck_fall && nbits_o >= CNT_W'(8) && op_o == OP_STATUS) begin
        miso_q <= status_i[rd_idx];
        rd_idx <= rd_idx - 1'b1;
      end
    end
  end

  assign miso_o    = miso_q & active;
  assign cmd_end_o = cs_rise & active;
  assign idx_o     = addr_q[ARR_AW-1:SUB_AW];

  p_lock_frame_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_fall && lock_i) |=> !active);
endmodule

// File: rtl/sfe_erase_seq.sv
module sfe_erase_seq #(
  parameter int SUB_AW      = 4,
  parameter int IDX_W       = 3,
  parameter int ERASE_CYC   = 400,
  parameter int WEL_CLR_CYC = 300
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic                    busy_o,
  output logic                    wel_clr_o,
  output logic                    we_o,
  output logic [IDX_W+SUB_AW-1:0] waddr_o
);
  localparam int TW        = $clog2(ERASE_CYC);
  localparam int SUB_BYTES = 1 << SUB_AW;

  logic [TW-1:0]    tmr;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      tmr    <= '0;
      idx_q  <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      tmr    <= '0;
      idx_q  <= idx_i;
    end else if (busy_o) begin
      if (tmr == TW'(ERASE_CYC - 1)) busy_o <= 1'b0;
      else tmr <= tmr + 1'b1;
    end
  end

  // one byte per clock, then idle out the rest of the cycle time
  assign we_o      = busy_o && ({1'b0, tmr} < (TW+1)'(SUB_BYTES));
  assign waddr_o   = {idx_q, tmr[SUB_AW-1:0]};
  assign wel_clr_o = busy_o && (tmr == TW'(WEL_CLR_CYC));

  p_busy_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tmr != TW'(ERASE_CYC - 1)) |=> busy_o);
  p_target_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(idx_q));
endmodule

// File: rtl/sfe_array.sv
module sfe_array #(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          ers_we_i,
  input  logic [AW-1:0] ers_addr_i,
  input  logic          bk_we_i,
  input  logic [AW-1:0] bk_addr_i,
  input  logic [7:0]    bk_wdata_i,
  output logic [7:0]    bk_rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  // non-volatile: no reset; erase wins over the test port
  always_ff @(posedge clk_i) begin
    if (ers_we_i) mem[ers_addr_i] <= 8'hFF;
    else if (bk_we_i) mem[bk_addr_i] <= bk_wdata_i;
  end

  assign bk_rdata_o = mem[bk_addr_i];
endmodule

// File: rtl/sfe_subsector_erase.sv
module sfe_subsector_erase
  import sfe_pkg::*;
#(
  parameter int ARR_AW      = 7,
  parameter int SUB_AW      = 4,
  parameter int ERASE_CYC   = 400,
  parameter int WEL_CLR_CYC = 300,
  parameter int REC_CYC     = 20,
  localparam int NSUB       = 1 << (ARR_AW - SUB_AW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic [NSUB-1:0]   prot_i,
  input  logic              mem_we_i,
  input  logic [ARR_AW-1:0] mem_addr_i,
  input  logic [7:0]        mem_wdata_i,
  output logic [7:0]        mem_rdata_o
);
  localparam int IDX_W = ARR_AW - SUB_AW;
  localparam int RW    = $clog2(REC_CYC + 1);

  logic             cmd_end, busy, wel, wel_clr, ers_we, start, wren_ok;
  logic [CNT_W-1:0] nbits;
  logic [7:0]       op, status;
  logic [IDX_W-1:0] idx;
  logic [ARR_AW-1:0] ers_addr;
  logic [RW-1:0]    rec_cnt;

  wire lock = (rec_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rec_cnt <= RW'(REC_CYC);
    else if (lock) rec_cnt <= rec_cnt - 1'b1;
  end

  always_comb begin
    status           = '0;
    status[BUSY_BIT] = busy;
    status[WEL_BIT]  = wel;
  end

  sfe_spi_rx #(.ARR_AW(ARR_AW), .SUB_AW(SUB_AW)) u_rx (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .mosi_i,
    .lock_i(lock), .status_i(status), .miso_o,
    .cmd_end_o(cmd_end), .nbits_o(nbits), .op_o(op), .idx_o(idx)
  );

  assign wren_ok = cmd_end && op == OP_WREN && nbits == CNT_W'(8) && !busy;
  assign start   = cmd_end && op == OP_SUBERS && nbits == CNT_W'(32)
                   && wel && !busy && !prot_i[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wel <= 1'b0;
    else if (wel_clr) wel <= 1'b0;
    else if (wren_ok) wel <= 1'b1;
  end

  sfe_erase_seq #(
    .SUB_AW(SUB_AW), .IDX_W(IDX_W),
    .ERASE_CYC(ERASE_CYC), .WEL_CLR_CYC(WEL_CLR_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .start_i(start), .idx_i(idx),
    .busy_o(busy), .wel_clr_o(wel_clr), .we_o(ers_we), .waddr_o(ers_addr)
  );

  sfe_array #(.AW(ARR_AW)) u_mem (
    .clk_i, .ers_we_i(ers_we), .ers_addr_i(ers_addr),
    .bk_we_i(mem_we_i), .bk_addr_i(mem_addr_i),
    .bk_wdata_i(mem_wdata_i), .bk_rdata_o(mem_rdata_o)
  );

  p_start_wel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> wel);
  p_start_unprot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> !prot_i[idx]);
  p_wel_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !wel);
  p_no_start_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |-> !start);
endmodule

// File: tb/sim_sfe_subsector_erase.sv
module sim_sfe_subsector_erase;
  localparam int ERASE = 400;
  localparam int WELC  = 300;
  localparam int REC   = 20;
  localparam int NB    = 128;

  typedef struct packed {
    logic        wren;
    logic [7:0]  op;
    logic [23:0] addr;
    logic [5:0]  nbits;
    logic [7:0]  prot;
    logic        erased;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b1, 8'h20, 24'h000020, 6'd32, 8'h00, 1'b1, 4'd4},   // R4 plain erase sub 2
    '{1'b0, 8'h20, 24'h000020, 6'd32, 8'h00, 1'b0, 4'd1},   // R1 no latch
    '{1'b1, 8'h20, 24'h000020, 6'd31, 8'h00, 1'b0, 4'd3},   // R3 short
    '{1'b1, 8'h20, 24'h000020, 6'd36, 8'h00, 1'b0, 4'd3},   // R3 mid byte
    '{1'b1, 8'h20, 24'h000020, 6'd40, 8'h00, 1'b0, 4'd3},   // R3 extra byte
    '{1'b1, 8'h20, 24'h000020, 6'd32, 8'h04, 1'b0, 4'd7},   // R7 protected
    '{1'b1, 8'h20, 24'hFFFFB5, 6'd32, 8'h00, 1'b1, 4'd11},  // R11 high bits set, sub 3
    '{1'b1, 8'h20, 24'h00004F, 6'd32, 8'h00, 1'b1, 4'd4},   // R4 last offset, sub 4
    '{1'b1, 8'h21, 24'h000020, 6'd32, 8'h00, 1'b0, 4'd12}   // R12 unknown opcode
  };

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, mosi = 0, miso;
  logic [7:0] prot = '0;
  logic mem_we = 0;
  logic [6:0] mem_addr = '0;
  logic [7:0] mem_wdata = '0, mem_rdata;
  logic [7:0] rd_buf [16];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sfe_subsector_erase #(.ERASE_CYC(ERASE), .WEL_CLR_CYC(WELC), .REC_CYC(REC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .mosi_i(mosi),
    .miso_o(miso), .prot_i(prot), .mem_we_i(mem_we), .mem_addr_i(mem_addr),
    .mem_wdata_i(mem_wdata), .mem_rdata_o(mem_rdata)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_bit(logic b);
    mosi = b; tick(2); sck = 1; tick(2); sck = 0;
  endtask

  task automatic frame(logic [47:0] bits, int n);
    cs_n = 0; tick(2);
    for (int i = 0; i < n; i++) spi_bit(bits[47-i]);
    tick(2); cs_n = 1; tick(2);
  endtask

  task automatic wren();
    frame({8'h06, 40'h0}, 8);
  endtask

  task automatic erase(logic [23:0] a);
    frame({8'h20, a, 16'h0}, 32);
  endtask

  task automatic read_status(int nb);
    cs_n = 0; tick(2);
    for (int i = 0; i < 8; i++) spi_bit(8'h05 >> (7 - i));
    for (int k = 0; k < nb; k++)
      for (int j = 0; j < 8; j++) begin
        mosi = 0; tick(2); rd_buf[k][7-j] = miso; sck = 1; tick(2); sck = 0;
      end
    tick(2); cs_n = 1; tick(2);
  endtask

  task automatic do_reset();
    rst_n = 0; tick(2); rst_n = 1;
  endtask

  task automatic preload();
    mem_we = 1;
    for (int i = 0; i < NB; i++) begin
      mem_addr = 7'(i); mem_wdata = pat(i); tick(1);
    end
    mem_we = 0;
  endtask

  // count bytes differing from the expectation; sub < 0 means none erased
  task automatic mem_check(int sub, string req);
    int bad = 0; logic [7:0] a = 0, e = 0, fa = 0, fe = 0;
    for (int i = 0; i < NB; i++) begin
      mem_addr = 7'(i); #1;
      e = (i / 16 == sub) ? 8'hFF : pat(i);
      a = mem_rdata;
      if (a !== e) begin
        if (bad == 0) begin fa = a; fe = e; end
        bad++;
      end
    end
    check(bad == 0, req, {24'h0, fa}, {24'h0, fe});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seen01, seen02;
    tick(3); rst_n = 1; tick(REC + 5);

    // reset state
    check(miso === 1'b0, "R5 idle miso", {31'h0, miso}, 0);
    read_status(1);
    check(rd_buf[0] === 8'h00, "R5 reset status", {24'h0, rd_buf[0]}, 32'h00);
    wren(); read_status(2);
    check(rd_buf[0] === 8'h02, "R2 latch set", {24'h0, rd_buf[0]}, 32'h02);
    check(rd_buf[1] === 8'h02, "R5 status repeats", {24'h0, rd_buf[1]}, 32'h02);

    // vector table
    foreach (VECS[v]) begin
      do_reset(); tick(REC + 5);
      prot = VECS[v].prot;
      preload();
      if (VECS[v].wren) wren();
      frame({VECS[v].op, VECS[v].addr, 16'h0}, int'(VECS[v].nbits));
      tick(ERASE + 20);
      mem_check(VECS[v].erased ? int'(VECS[v].addr[6:4]) : -1,
                $sformatf("R%0d vector %0d", VECS[v].req, v));
      prot = '0;
    end

    // status timeline through one erase
    do_reset(); tick(REC + 5); preload();
    wren(); erase(24'h000007);
    read_status(14);
    check(rd_buf[0] === 8'h03, "R5 busy at start", {24'h0, rd_buf[0]}, 32'h03);
    seen01 = 0; seen02 = 0;
    for (int k = 0; k < 14; k++) begin
      if (rd_buf[k] === 8'h01) seen01++;
      if (rd_buf[k] === 8'h02) seen02++;
    end
    check(seen01 > 0, "R6 latch cleared while busy", seen01, 1);
    check(seen02 == 0, "R6 latch never outlives busy", seen02, 0);
    check(rd_buf[13] === 8'h00, "R5 idle after erase", {24'h0, rd_buf[13]}, 32'h00);
    mem_check(0, "R4 sub 0 erased");

    // second commands during a running erase
    do_reset(); tick(REC + 5); preload();
    wren(); erase(24'h000010);
    wren(); erase(24'h000050);
    read_status(1);
    check(rd_buf[0] === 8'h03, "R8 first erase undisturbed", {24'h0, rd_buf[0]}, 32'h03);
    tick(ERASE + 20);
    mem_check(1, "R8 only first subsector erased");

    // reset during erase
    do_reset(); tick(REC + 5); preload();
    wren(); erase(24'h000060);
    tick(2); do_reset(); tick(REC + 5);
    read_status(1);
    check(rd_buf[0] === 8'h00, "R9 status after abort", {24'h0, rd_buf[0]}, 32'h00);
    tick(ERASE + 20);
    mem_addr = 7'd111; #1;
    check(mem_rdata === pat(111), "R9 unreached byte kept", {24'h0, mem_rdata}, {24'h0, pat(111)});

    // recovery lockout
    do_reset();
    wren(); tick(REC + 5);
    read_status(1);
    check(rd_buf[0] === 8'h00, "R10 frame in lockout ignored", {24'h0, rd_buf[0]}, 32'h00);
    wren(); read_status(1);
    check(rd_buf[0] === 8'h02, "R10 frame after lockout works", {24'h0, rd_buf[0]}, 32'h02);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule